// File: doc/BRIEF.md
# Non-Overlapping Multi-Phase Clock Generator

The block derives the timing phases for a two-phase switched-capacitor pipeline converter from one fast reference clock. A tick counter splits each conversion period into two equal halves. Set one owns the first half and set two owns the second. Each set has three phases. A sample phase marks the sampling instant with its falling edge. A wider settle phase gives the residue amplifier time to settle. A short latch pulse fires the dynamic comparator after the sample phase has dropped and ends before the settle phase does.

Every set also drives a comparator reset strobe, which is the inverse of its latch. Because the dynamic comparator returns to reset once its latch ends, the block stores the comparator decision bits of each set at the end of that set's latch pulse. It holds them until the same set latches again.

All timing is set in fast-clock ticks: the period, the sample width, the latch offset and width, and the dead gap between sets. The settle width is the half period minus the gap. Any parameter set that breaks the ordering rules stops elaboration.

Top module: `nonoverlap_clkgen`

## Requirements
- R1: While rst_ni is low, every phase output is 0, both reset strobes are 1 and all decision bits are 0. On the first rising clock edge after release, only the set-one sample phase (bit 0 of samp_o) and the set-one settle phase (bit 0 of setl_o) go high.
- R2: The phase pattern repeats every PERIOD ticks. Set two (bit 1 of each phase vector) repeats the set-one pattern shifted by PERIOD/2 ticks.
- R3: Within its half period, each sample phase is high for the first SAMP_W ticks. Each settle phase starts together with its sample phase and is high for PERIOD/2-GAP ticks, which is longer than SAMP_W.
- R4: Each latch phase rises LAT_OFS ticks after its sample phase rises and stays high for LAT_W ticks. LAT_OFS exceeds SAMP_W, so no sample phase is high or changes while any latch is high.
- R5: Each latch pulse lies inside the settle phase of its own set. The settle phase is still high in the tick where the latch falls.
- R6: Set-one sample or settle is never high in the same tick as set-two sample or settle. At least GAP all-low ticks separate the two sets.
- R7: Each comparator reset strobe (crst_o bit s) is the inverse of latch bit s in every tick.
- R8: On the clock edge where latch s falls, cmp_i[s] is copied into dec_o[s]. Changes on cmp_i[s] at any other time have no effect on dec_o[s] until the next fall of latch s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_i | input | 2 x NCMP | Raw comparator outputs, index 0 set one, index 1 set two |
| samp_o | output | 2 | Sample phases, bit 0 set one |
| setl_o | output | 2 | Settle (amplify) phases |
| lat_o | output | 2 | Comparator latch pulses |
| crst_o | output | 2 | Comparator reset strobes, inverse of lat_o |
| dec_o | output | 2 x NCMP | Held decision bits per set |

## Verification
Two events share one clock edge: the end of a latch pulse and the capture of that set's decision bits. In the same cycle the settle phase must still be high. The bench sets new comparator values before each latch and checks the captured value in the tick after the fall. It then drives the complement onto the comparator inputs for the rest of the half period, and confirms that the held bits stay put and that settle never drops before its latch.

// File: rtl/nocg_pkg.sv
package nocg_pkg;

  // ordering rules for the phase plan, all values in fast-clock ticks
  function automatic bit timing_ok(int period, int samp_w, int lat_ofs, int lat_w, int gap);
    int half;
    int setl_w;
    half   = period / 2;
    setl_w = half - gap;
    return (period % 2 == 0) && (gap >= 1) && (samp_w >= 1) &&
           (setl_w > samp_w) && (lat_ofs > samp_w) && (lat_w >= 1) &&
           (lat_ofs + lat_w <= setl_w) && (2 * lat_w <= half - samp_w);
  endfunction

endpackage

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int PERIOD = 20,
  parameter int CW     = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_o <= '0;
    else if (cnt_o == LAST) cnt_o <= '0;
    else                    cnt_o <= cnt_o + 1'b1;
  end

  p_cnt_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == LAST) |=> (cnt_o == '0));
  p_cnt_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o <= LAST);
endmodule

// File: rtl/decision_hold.sv
module decision_hold #(
  parameter int NCMP = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            lat_q_i,
  input  logic            lat_d_i,
  input  logic [NCMP-1:0] cmp_i,
  output logic [NCMP-1:0] dec_o
);
  logic cap;
  // store on the edge where the latch drops; comparator still holds its decision
  assign cap = lat_q_i & ~lat_d_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  dec_o <= '0;
    else if (cap) dec_o <= cmp_i;
  end
endmodule

// File: rtl/phase_slot.sv
module phase_slot #(
  parameter int HALF    = 10,
  parameter int OFS     = 0,
  parameter int SAMP_W  = 4,
  parameter int SETL_W  = 9,
  parameter int LAT_OFS = 5,
  parameter int LAT_W   = 3,
  parameter int NCMP    = 2,
  parameter int CW      = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [CW-1:0]   cnt_i,
  input  logic [NCMP-1:0] cmp_i,
  output logic            samp_o,
  output logic            setl_o,
  output logic            lat_o,
  output logic            crst_o,
  output logic [NCMP-1:0] dec_o
);
  localparam logic [CW-1:0] OFS_C  = CW'(OFS);
  localparam logic [CW-1:0] END_C  = CW'(OFS + HALF);
  localparam logic [CW-1:0] SAMP_C = CW'(SAMP_W);
  localparam logic [CW-1:0] SETL_C = CW'(SETL_W);
  localparam logic [CW-1:0] LON_C  = CW'(LAT_OFS);
  localparam logic [CW-1:0] LOFF_C = CW'(LAT_OFS + LAT_W);

  logic          in_half;
  logic [CW-1:0] rel;
  logic          samp_d, setl_d, lat_d;

  assign in_half = (cnt_i >= OFS_C) && (cnt_i < END_C);
  assign rel     = cnt_i - OFS_C;
  assign samp_d  = in_half && (rel < SAMP_C);
  assign setl_d  = in_half && (rel < SETL_C);
  assign lat_d   = in_half && (rel >= LON_C) && (rel < LOFF_C);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      samp_o <= 1'b0;
      setl_o <= 1'b0;
      lat_o  <= 1'b0;
      crst_o <= 1'b1;
    end else begin
      samp_o <= samp_d;
      setl_o <= setl_d;
      lat_o  <= lat_d;
      crst_o <= ~lat_d;
    end
  end

  decision_hold #(.NCMP(NCMP)) i_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lat_q_i (lat_o),
    .lat_d_i (lat_d),
    .cmp_i   (cmp_i),
    .dec_o   (dec_o)
  );

  p_lat_in_setl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lat_o |-> setl_o);
  p_setl_past_lat_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lat_o) |-> setl_o);
  p_setl_outlasts_samp_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(setl_o) |-> (!samp_o && $past(!samp_o)));
  p_strobe_inv_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crst_o != lat_o);
  p_dec_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lat_o |=> $stable(dec_o));
endmodule

// File: rtl/nonoverlap_clkgen.sv
module nonoverlap_clkgen #(
  parameter int PERIOD  = 20,
  parameter int SAMP_W  = 4,
  parameter int LAT_OFS = 5,
  parameter int LAT_W   = 3,
  parameter int GAP     = 1,
  parameter int NCMP    = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [1:0][NCMP-1:0] cmp_i,
  output logic [1:0]           samp_o,
  output logic [1:0]           setl_o,
  output logic [1:0]           lat_o,
  output logic [1:0]           crst_o,
  output logic [1:0][NCMP-1:0] dec_o
);
  localparam int HALF   = PERIOD / 2;
  localparam int SETL_W = HALF - GAP;
  localparam int CW     = $clog2(PERIOD + 1);

  if (!nocg_pkg::timing_ok(PERIOD, SAMP_W, LAT_OFS, LAT_W, GAP)) begin : g_bad_timing
    $error("nonoverlap_clkgen: phase parameters violate ordering rules");
  end

  logic [CW-1:0] cnt;

  tick_counter #(.PERIOD(PERIOD), .CW(CW)) i_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_o  (cnt)
  );

  for (genvar s = 0; s < 2; s++) begin : g_set
    phase_slot #(
      .HALF(HALF), .OFS(s * HALF), .SAMP_W(SAMP_W), .SETL_W(SETL_W),
      .LAT_OFS(LAT_OFS), .LAT_W(LAT_W), .NCMP(NCMP), .CW(CW)
    ) i_slot (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cnt_i  (cnt),
      .cmp_i  (cmp_i[s]),
      .samp_o (samp_o[s]),
      .setl_o (setl_o[s]),
      .lat_o  (lat_o[s]),
      .crst_o (crst_o[s]),
      .dec_o  (dec_o[s])
    );
  end

  p_sets_apart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((samp_o[0] | setl_o[0]) && (samp_o[1] | setl_o[1])));
  p_lat_no_samp_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|lat_o) |-> (samp_o == 2'b00));
  p_lat_samp_still_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|lat_o) |-> $stable(samp_o));
endmodule

// File: tb/test_nonoverlap_clkgen.sv
module test_nonoverlap_clkgen;
  localparam int NCMP = 2;

  logic                 clk_i = 1'b0;
  logic                 rst_ni = 1'b0;
  logic [1:0][NCMP-1:0] cmp_i = '0;
  logic [1:0]           samp_o, setl_o, lat_o, crst_o;
  logic [1:0][NCMP-1:0] dec_o;

  int  n_chk = 0;
  int  n_err = 0;
  bit  done  = 1'b0;

  always #5 clk_i = ~clk_i;

  nonoverlap_clkgen #(.NCMP(NCMP)) i_nonoverlap_clkgen (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmp_i(cmp_i),
    .samp_o(samp_o), .setl_o(setl_o), .lat_o(lat_o),
    .crst_o(crst_o), .dec_o(dec_o)
  );

  // per tick: {lat2, setl2, samp2, lat1, setl1, samp1}
  localparam logic [5:0] EXP_TAB [20] = '{
    6'b000011, 6'b000011, 6'b000011, 6'b000011, 6'b000010,
    6'b000110, 6'b000110, 6'b000110, 6'b000010, 6'b000000,
    6'b011000, 6'b011000, 6'b011000, 6'b011000, 6'b010000,
    6'b110000, 6'b110000, 6'b110000, 6'b010000, 6'b000000
  };
  localparam logic [1:0] PAT_A [3] = '{2'b01, 2'b10, 2'b11};
  localparam logic [1:0] PAT_B [3] = '{2'b10, 2'b11, 2'b01};

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_tick(input int t);
    logic [5:0] e;
    e = EXP_TAB[t];
    chk("R2 R3 sample", {6'd0, samp_o}, {6'd0, e[3], e[0]});
    chk("R3 R5 settle", {6'd0, setl_o}, {6'd0, e[4], e[1]});
    chk("R4 latch",     {6'd0, lat_o},  {6'd0, e[5], e[2]});
    chk("R7 strobe",    {6'd0, crst_o}, {6'd0, ~e[5], ~e[2]});
    chk("R6 apart", {7'd0, (samp_o[0] | setl_o[0]) & (samp_o[1] | setl_o[1])}, 8'd0);
  endtask

  task automatic chk_reset_state();
    chk("R1 phases", {2'd0, samp_o, setl_o, lat_o}, 8'd0);
    chk("R1 strobes", {6'd0, crst_o}, 8'd3);
    chk("R1 decisions", {4'd0, dec_o}, 8'd0);
  endtask

  initial begin
    cmp_i[0] = PAT_A[0];
    repeat (3) @(negedge clk_i);
    chk_reset_state();
    rst_ni = 1'b1;

    for (int n = 0; n < 60; n++) begin
      int t;
      int r;
      @(negedge clk_i);
      t = n % 20;
      r = n / 20;
      chk_tick(t);
      if (t == 8) chk("R8 capture set1", {6'd0, dec_o[0]}, {6'd0, PAT_A[r]});
      if (t == 9) begin
        if (r > 0) chk("R8 hold set2", {6'd0, dec_o[1]}, {6'd0, PAT_B[r-1]});
        cmp_i[0] = ~PAT_A[r];
        cmp_i[1] = PAT_B[r];
      end
      if (t == 18) chk("R8 capture set2", {6'd0, dec_o[1]}, {6'd0, PAT_B[r]});
      if (t == 19) begin
        chk("R8 hold set1", {6'd0, dec_o[0]}, {6'd0, PAT_A[r]});
        cmp_i[0] = PAT_A[(r + 1) % 3];
        cmp_i[1] = ~PAT_B[r];
      end
    end

    // reset in the middle of a latch pulse
    repeat (6) @(negedge clk_i);
    chk("R4 latch before reset", {6'd0, lat_o}, 8'd1);
    rst_ni = 1'b0;
    #1;
    chk_reset_state();
    @(negedge clk_i);
    chk_reset_state();
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 first phases", {2'd0, samp_o, setl_o, lat_o}, {2'd0, 2'b01, 2'b01, 2'b00});
    chk_tick(0);
    @(negedge clk_i);
    chk_tick(1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end
endmodule